// File: doc/BRIEF.md
# Push-button Stereo Volume Controller

This block is the digital control unit of a two-channel stepped attenuator. Three active-low push buttons (raise, lower, mute) are synchronised and filtered. The block then keeps one attenuation index that both channels share. Code 0 is the loudest step, 31 is the quietest step and 32 stands for mute. A slow clock-enable tick, nominally 1 kHz, drives every timing decision. All durations are parameters counted in ticks, so a bench can run on scaled time.

Each accepted command that changes the index produces a one-cycle `cmd_valid` strobe, with the new index on `cmd_index`. These go to the zero-crossing gate that switches the resistor arrays. A held raise or lower button repeats: first at a slow rate, then at a faster one. A fresh press that arrives too soon after a command is thrown away. Presses on more than one button at once are also thrown away. Standby parks the wiper at the bias end and leaves the stored index untouched.

Top module: `vol_ctrl`

## Requirements
- R1: `cmd_index` is 6 bits wide and always lies in 0..32. Codes 0..31 are attenuation steps, with 0 the least attenuation, and 32 is the mute code.
- R2: After reset, the index and `wiper_pos` are both 10 and `cmd_valid` is low.
- R3: A button counts as pressed only after its synchronised low level has held for DEB_TICKS consecutive ticks. A shorter low pulse issues no command.
- R4: A raise command lowers the index by one and a lower command raises it by one. The index stops at 0 and at 31 without wrapping. A command that leaves the index unchanged produces no `cmd_valid`.
- R5: While raise or lower stays held, a repeat step fires HOLD_TICKS after the press was accepted. Further steps follow every SLOW_TICKS for SLOW_SPAN ticks, then every FAST_TICKS until release.
- R6: A mute press on an unmuted index stores that index and moves to 32. A mute press on index 32 restores the stored index. A held mute button never repeats.
- R7: While muted, a raise press restores the stored index, and a lower press is ignored.
- R8: A new press accepted within LOCK_TICKS of the last command is discarded. Nothing is issued until all buttons are released.
- R9: When more than one button is pressed at once, no command is issued. The block waits until every button is released.
- R10: While `stby_n` is low, `wiper_pos` is 32 and button presses are ignored. When `stby_n` returns high, `wiper_pos` returns to the unchanged index.
- R11: `cmd_valid` is high for exactly one cycle per index change. In that cycle `cmd_index` already holds the new index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timing enable, nominally every 1 ms |
| up_n | input | 1 | Raise-volume button, active low, asynchronous |
| dn_n | input | 1 | Lower-volume button, active low, asynchronous |
| mute_n | input | 1 | Mute toggle button, active low, asynchronous |
| stby_n | input | 1 | Standby request, active low, asynchronous |
| cmd_valid | output | 1 | One-cycle strobe for a new target index |
| cmd_index | output | 6 | Current and target attenuation index |
| wiper_pos | output | 6 | Effective tap: the index, or 32 in standby |

## Verification
A wrong index or a lost mute save shows up at `cmd_index` on the very next command strobe, within one cycle of the decision. A broken repeat or lockout counter shows up as strobes at the wrong tick spacing, or as strobes that should never appear. The directed scenarios therefore record the cycle of every strobe, as well as its value. A stuck standby or filter state shows up on `wiper_pos` a few cycles after the input changes, or as a missing strobe after a press.

// File: rtl/vol_pkg.sv
// Shared types for the push-button volume controller.
// Assumes three buttons, indexed raise=0, lower=1, mute=2.
package vol_pkg;
    localparam int NBTN = 3;

    typedef enum logic [1:0] {
        K_UP   = 2'd0,
        K_DN   = 2'd1,
        K_MUTE = 2'd2
    } key_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HELD = 2'd1,
        S_DROP = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        P_WAIT = 2'd0,
        P_SLOW = 2'd1,
        P_FAST = 2'd2
    } rep_phase_e;
endpackage

// File: rtl/vol_debounce.sv
// Synchronises one active-low button and filters it.
// The filtered level follows the raw level only after the raw level has
// differed from it for DEB_TICKS consecutive ticks.
// Assumes tick is a one-cycle enable in the clk domain.
module vol_debounce #(
    parameter int DEB_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw_n,
    output logic pressed
);
    localparam int CW = $clog2(DEB_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

    logic s1, s2;
    logic [CW-1:0] cnt;

    // Two-flop synchroniser; idles in the released state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= raw_n;
            s2 <= s1;
        end
    end

    // Count ticks of disagreement; flip the filtered level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pressed <= 1'b0;
        end else if (~s2 == pressed) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                pressed <= ~s2;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pressed) |-> $past(tick)); // R3
endmodule

// File: rtl/vol_seq.sv
// Command sequencer: accepts a single clean press, runs auto-repeat,
// enforces the post-command lockout, and drops clashing presses.
// Assumes pressed[] is already debounced, with bit 0 raise, bit 1 lower
// and bit 2 mute. Repeat steps of a held button bypass the lockout.
module vol_seq
    import vol_pkg::*;
#(
    parameter int HOLD_TICKS = 1000,
    parameter int SLOW_TICKS = 250,
    parameter int SLOW_SPAN  = 4000,
    parameter int FAST_TICKS = 125,
    parameter int LOCK_TICKS = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NBTN-1:0] pressed,
    input  logic            standby,
    output logic            go,
    output key_e            go_key
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam int SW = $clog2(SLOW_SPAN + 1);
    localparam int RW = $clog2(((SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS) + 1);
    localparam int LW = $clog2(LOCK_TICKS + 1);

    seq_state_e      state;
    rep_phase_e      phase;
    key_e            sel;
    key_e            press_key;
    logic [HW-1:0]   wait_cnt;
    logic [SW-1:0]   span_cnt;
    logic [RW-1:0]   rep_cnt;
    logic [RW-1:0]   rep_last;
    logic [LW-1:0]   lock_cnt;
    logic [NBTN-1:0] sel_mask;
    logic            accept, still, rep_fire;

    // Decode the single pressed button and the held-button status.
    always_comb begin
        press_key = pressed[0] ? K_UP : (pressed[1] ? K_DN : K_MUTE);
        sel_mask  = NBTN'(1) << sel;
        rep_last  = (phase == P_SLOW) ? RW'(SLOW_TICKS - 1) : RW'(FAST_TICKS - 1);
        accept    = (state == S_IDLE) && !standby && $onehot(pressed) && (lock_cnt == '0);
        still     = (state == S_HELD) && !standby && (pressed == sel_mask);
        rep_fire  = still && tick && (sel != K_MUTE) &&
                    (((phase == P_WAIT) && (wait_cnt == HW'(HOLD_TICKS - 1))) ||
                     ((phase != P_WAIT) && (rep_cnt == rep_last)));
        go        = accept || rep_fire;
        go_key    = accept ? press_key : sel;
    end

    // Top-level sequencing between idle, held and discard states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            sel   <= K_UP;
        end else begin
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        state <= S_HELD;
                        sel   <= press_key;
                    end else if (pressed != '0) begin
                        state <= S_DROP;
                    end
                end
                S_HELD: begin
                    if (!still) state <= (pressed == '0) ? S_IDLE : S_DROP;
                end
                default: begin
                    if (pressed == '0) state <= S_IDLE;
                end
            endcase
        end
    end

    // Auto-repeat timers: initial hold, slow stage, then fast stage.
    always_ff @(posedge clk) begin
        if (!rst_n || accept) begin
            phase    <= P_WAIT;
            wait_cnt <= '0;
            span_cnt <= '0;
            rep_cnt  <= '0;
        end else if (still && tick && (sel != K_MUTE)) begin
            case (phase)
                P_WAIT: begin
                    if (wait_cnt == HW'(HOLD_TICKS - 1)) begin
                        phase    <= P_SLOW;
                        rep_cnt  <= '0;
                        span_cnt <= '0;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                P_SLOW: begin
                    if (span_cnt == SW'(SLOW_SPAN - 1)) begin
                        phase   <= P_FAST;
                        rep_cnt <= '0;
                    end else begin
                        span_cnt <= span_cnt + 1'b1;
                        rep_cnt  <= (rep_cnt == rep_last) ? '0 : rep_cnt + 1'b1;
                    end
                end
                default: rep_cnt <= (rep_cnt == rep_last) ? '0 : rep_cnt + 1'b1;
            endcase
        end
    end

    // Lockout window restarted by every issued command.
    always_ff @(posedge clk) begin
        if (!rst_n)                     lock_cnt <= '0;
        else if (go)                    lock_cnt <= LW'(LOCK_TICKS);
        else if (tick && lock_cnt != 0) lock_cnt <= lock_cnt - 1'b1;
    end

    AST_CLASH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) && !$onehot0(pressed) |-> !go); // R9
    AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !go); // R10
    AST_MUTE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HELD) && (sel == K_MUTE) |-> !go); // R6
    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DROP) |-> !go); // R8
endmodule

// File: rtl/vol_index.sv
// Attenuation index register with mute save/restore and saturation.
// Produces a one-cycle strobe whenever a command changes the index.
// Assumes go is a one-cycle request qualified by go_key.
module vol_index
    import vol_pkg::*;
#(
    parameter int STEPS     = 32,
    parameter int RESET_IDX = 10,
    parameter int IW        = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  key_e          go_key,
    output logic [IW-1:0] idx,
    output logic          cmd_valid
);
    localparam logic [IW-1:0] MUTE_CODE = IW'(STEPS);
    localparam logic [IW-1:0] BOTTOM    = IW'(STEPS - 1);

    logic [IW-1:0] saved, nxt, nsave;

    // Next index and saved index for the requested command.
    always_comb begin
        nxt   = idx;
        nsave = saved;
        case (go_key)
            K_UP: begin
                if (idx == MUTE_CODE) nxt = saved;
                else if (idx != '0)   nxt = idx - 1'b1;
            end
            K_DN: begin
                if (idx < BOTTOM) nxt = idx + 1'b1;
            end
            default: begin
                if (idx == MUTE_CODE) begin
                    nxt = saved;
                end else begin
                    nxt   = MUTE_CODE;
                    nsave = idx;
                end
            end
        endcase
    end

    // Commit the command and flag a real change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx       <= IW'(RESET_IDX);
            saved     <= IW'(RESET_IDX);
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= go && (nxt != idx);
            if (go) begin
                idx   <= nxt;
                saved <= nsave;
            end
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= MUTE_CODE); // R1
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        go && (go_key == K_UP) && (idx != MUTE_CODE) && (idx != '0) |=> idx == $past(idx) - 1'b1); // R4
    AST_DN_WHILE_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
        go && (go_key == K_DN) && (idx == MUTE_CODE) |=> (idx == MUTE_CODE) && !cmd_valid); // R7
    AST_STROBE_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> idx != $past(idx)); // R11
endmodule

// File: rtl/vol_ctrl.sv
// Top of the push-button volume controller: button filters, command
// sequencer, index register and standby parking of the wiper.
// Assumes all button and standby pins are asynchronous and active low.
module vol_ctrl
    import vol_pkg::*;
#(
    parameter int STEPS      = 32,
    parameter int RESET_IDX  = 10,
    parameter int DEB_TICKS  = 50,
    parameter int LOCK_TICKS = 40,
    parameter int HOLD_TICKS = 1000,
    parameter int SLOW_TICKS = 250,
    parameter int SLOW_SPAN  = 4000,
    parameter int FAST_TICKS = 125,
    parameter int IW         = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          up_n,
    input  logic          dn_n,
    input  logic          mute_n,
    input  logic          stby_n,
    output logic          cmd_valid,
    output logic [IW-1:0] cmd_index,
    output logic [IW-1:0] wiper_pos
);
    logic [NBTN-1:0] btn_n, pressed;
    logic            sb1, sb2, standby, go;
    key_e            go_key;
    logic [IW-1:0]   idx;

    assign btn_n = {mute_n, dn_n, up_n};

    for (genvar b = 0; b < NBTN; b++) begin : g_btn
        vol_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .raw_n  (btn_n[b]),
            .pressed(pressed[b])
        );
    end

    // Synchronise the standby request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb1 <= 1'b1;
            sb2 <= 1'b1;
        end else begin
            sb1 <= stby_n;
            sb2 <= sb1;
        end
    end
    assign standby = ~sb2;

    vol_seq #(
        .HOLD_TICKS(HOLD_TICKS), .SLOW_TICKS(SLOW_TICKS), .SLOW_SPAN(SLOW_SPAN),
        .FAST_TICKS(FAST_TICKS), .LOCK_TICKS(LOCK_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pressed(pressed),
        .standby(standby), .go(go), .go_key(go_key)
    );

    vol_index #(.STEPS(STEPS), .RESET_IDX(RESET_IDX), .IW(IW)) u_idx (
        .clk(clk), .rst_n(rst_n), .go(go), .go_key(go_key),
        .idx(idx), .cmd_valid(cmd_valid)
    );

    assign cmd_index = idx;
    assign wiper_pos = standby ? IW'(STEPS) : idx;

    AST_STBY_HOLDS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        standby && $past(standby) |-> $stable(cmd_index)); // R10
endmodule

// File: tb/vol_ctrl_tb.sv
// Directed bench for vol_ctrl on scaled time: one tick every two clocks.
module vol_ctrl_tb;
    localparam int DEB  = 3;
    localparam int LOCK = 12;
    localparam int HOLD = 20;
    localparam int SLOW = 5;
    localparam int SPAN = 20;
    localparam int FAST = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [2:0] btn_n = 3'b111;
    logic stby_n = 1'b1;
    logic cmd_valid;
    logic [5:0] cmd_index, wiper_pos;

    int vectors = 0;
    int fails = 0;
    int npulse = 0;
    int cyc = 0;
    int stamp [0:63];
    int pidx  [0:63];
    bit done = 1'b0;

    always #10 clk = ~clk;

    vol_ctrl #(
        .DEB_TICKS(DEB), .LOCK_TICKS(LOCK), .HOLD_TICKS(HOLD),
        .SLOW_TICKS(SLOW), .SLOW_SPAN(SPAN), .FAST_TICKS(FAST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .up_n(btn_n[0]), .dn_n(btn_n[1]), .mute_n(btn_n[2]), .stby_n(stby_n),
        .cmd_valid(cmd_valid), .cmd_index(cmd_index), .wiper_pos(wiper_pos)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n && cmd_valid) begin
            stamp[npulse % 64] = cyc;
            pidx[npulse % 64]  = int'(cmd_index);
            npulse = npulse + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic do_reset();
        btn_n  = 3'b111;
        stby_n = 1'b1;
        rst_n  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_ticks(2);
    endtask

    task automatic tap(input int b, input int low_ticks);
        btn_n[b] = 1'b0;
        wait_ticks(low_ticks);
        btn_n[b] = 1'b1;
        wait_ticks(DEB + LOCK + 3);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 wiper_pos after reset", int'(wiper_pos), 10);
        check("R2 cmd_valid after reset", int'(cmd_valid), 0);
        check("R1 cmd_index after reset", int'(cmd_index), 10);
    endtask

    task automatic t_debounce();
        int base;
        do_reset();
        base = npulse;
        tap(0, DEB - 2);
        check("R3 short pulse ignored", npulse - base, 0);
        tap(0, DEB + 3);
        check("R3 valid press one strobe", npulse - base, 1);
        check("R11 strobe carries new index", pidx[base % 64], 9);
    endtask

    task automatic t_saturate_top();
        int base;
        do_reset();
        base = npulse;
        for (int i = 0; i < 10; i++) tap(0, DEB + 2);
        check("R4 ten raises reach 0", int'(cmd_index), 0);
        check("R4 ten strobes", npulse - base, 10);
        tap(0, DEB + 2);
        check("R4 raise at 0 no strobe", npulse - base, 10);
        check("R4 index stays 0", int'(wiper_pos), 0);
    endtask

    task automatic t_repeat();
        int base, g;
        do_reset();
        base = npulse;
        btn_n[1] = 1'b0;
        wait_ticks(DEB + 3 + HOLD + SPAN + 3 * FAST);
        btn_n[1] = 1'b1;
        wait_ticks(DEB + LOCK + 3);
        g = stamp[(base + 1) % 64] - stamp[base % 64];
        check("R5 first repeat near HOLD", int'(g >= 2 * HOLD - 2 && g <= 2 * HOLD + 2), 1);
        for (int k = 1; k < 5; k++)
            check("R5 slow repeat spacing", stamp[(base + k + 1) % 64] - stamp[(base + k) % 64], 2 * SLOW);
        check("R5 fast repeat spacing", stamp[(base + 6) % 64] - stamp[(base + 5) % 64], 2 * FAST);
        check("R5 seventh strobe index", pidx[(base + 6) % 64], 17);
    endtask

    task automatic t_bottom_and_mute();
        int base;
        do_reset();
        base = npulse;
        btn_n[1] = 1'b0;
        wait_ticks(DEB + HOLD + SPAN + 25 * FAST);
        btn_n[1] = 1'b1;
        wait_ticks(DEB + LOCK + 3);
        check("R4 lower saturates at 31", int'(cmd_index), 31);
        check("R4 exactly 21 strobes to bottom", npulse - base, 21);
        tap(2, DEB + 2);
        check("R6 mute moves to 32", int'(cmd_index), 32);
        base = npulse;
        tap(1, DEB + 2);
        check("R7 lower while muted no strobe", npulse - base, 0);
        check("R7 lower while muted keeps 32", int'(wiper_pos), 32);
        tap(0, DEB + 2);
        check("R7 raise while muted restores", int'(cmd_index), 31);
    endtask

    task automatic t_mute_toggle();
        int base;
        do_reset();
        base = npulse;
        tap(2, DEB + HOLD + 10);
        check("R6 held mute single strobe", npulse - base, 1);
        check("R6 muted index", int'(wiper_pos), 32);
        tap(2, DEB + 2);
        check("R6 second mute restores", int'(cmd_index), 10);
    endtask

    task automatic t_clash();
        int base;
        do_reset();
        base = npulse;
        btn_n = 3'b100;
        wait_ticks(DEB + 5);
        btn_n = 3'b111;
        wait_ticks(DEB + LOCK + 3);
        check("R9 clash issues nothing", npulse - base, 0);
        check("R9 clash keeps index", int'(cmd_index), 10);
        tap(0, DEB + 2);
        check("R9 recovers after release", int'(cmd_index), 9);
    endtask

    task automatic t_lockout();
        int base;
        do_reset();
        base = npulse;
        btn_n[0] = 1'b0;
        wait_ticks(DEB + 2);
        btn_n[0] = 1'b1;
        wait_ticks(DEB + 1);
        btn_n[0] = 1'b0;
        wait_ticks(DEB + 2);
        btn_n[0] = 1'b1;
        wait_ticks(DEB + LOCK + 3);
        check("R8 press in lockout dropped", npulse - base, 1);
        check("R8 index after drop", int'(cmd_index), 9);
        tap(0, DEB + 2);
        check("R8 later press accepted", int'(cmd_index), 8);
    endtask

    task automatic t_standby();
        int base;
        do_reset();
        base = npulse;
        stby_n = 1'b0;
        wait_ticks(3);
        check("R10 standby parks wiper", int'(wiper_pos), 32);
        tap(0, DEB + 2);
        check("R10 press in standby ignored", npulse - base, 0);
        stby_n = 1'b1;
        wait_ticks(3);
        check("R10 wiper restored", int'(wiper_pos), 10);
        check("R10 index unchanged", int'(cmd_index), 10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_debounce();
        t_saturate_top();
        t_repeat();
        t_bottom_and_mute();
        t_mute_toggle();
        t_clash();
        t_lockout();
        t_standby();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule